// File: doc/BRIEF.md
# Graceful Stop and Transmit Polling Controller

This block sits beside the DMA control register of an Ethernet controller. It turns three control bits into timed actions: a receive stop request, a transmit stop request, and a wait-or-poll selector. When software asks one of the paths to stop, the block reports completion with a one-cycle event pulse. If that path has no frame in flight, the pulse comes at once. Otherwise it comes when the frame ends.

While polling is selected, a self-rearming timer counts ticks from an external prescaler. Each time the timer expires it asks the transmit engine to walk ring 0. No walk is asked for while the transmit stop bit is held. The default of 100 prescaled ticks per period gives 100 polls per second from a 10 kHz tick.

The block has three state machines. Two identical stop sequencers each have the states `STOP_IDLE`, `STOP_WAIT` and `STOP_FIRE`. Their transitions are:
- request-idle: from IDLE or FIRE to FIRE
- request-busy: from IDLE or FIRE to WAIT
- frame-end: from WAIT to FIRE
- cancel: from WAIT to IDLE
- retire: from FIRE to IDLE

The poll timer has the states `POLL_OFF`, `POLL_RUN` and `POLL_WALK`. Its transitions are:
- restart: from any state to RUN
- expire-walk: from RUN or WALK to WALK
- expire-quiet: from RUN or WALK to RUN
- expire-halt: from RUN or WALK to OFF
- walk-done: from WALK to RUN

Top module: `graceful_stop_poll`

## Requirements
- R1: While reset is held, and in the cycle after it is released, all four outputs are 0.
- R2: A write with the receive stop bit at 1 fires a `rx_stop_done` pulse in the next cycle when no receive frame is in flight. A frame is in flight when `rx_busy`=1 and `rx_frame_done`=0. A frame that ends in the write cycle therefore counts as not in flight.
- R3: A write with the receive stop bit at 1 while a receive frame is in flight holds back `rx_stop_done`. The pulse comes in the cycle after `rx_frame_done` is seen.
- R4: The transmit stop bit behaves as in R2 and R3, using `tx_busy`, `tx_frame_done` and `tx_stop_done`.
- R5: A write with a stop bit at 0 while that path's completion is pending cancels it. No pulse follows, even if the frame ends in the same cycle.
- R6: Each stop-done pulse lasts one cycle unless another qualifying write arrives. Every write with a stop bit at 1 produces its own completion.
- R7: A write with the wait bit at 0 restarts the poll timer with a full period. In the next cycle `poll_active`=1 and `ring0_walk`=0. The timer expires on the TICKS_PER_POLL-th `poll_tick` counted after the restart.
- R8: On expiry with the wait bit 0 and the transmit stop bit 0, `ring0_walk` pulses for one cycle and the timer rearms for another period.
- R9: On expiry with the transmit stop bit 1, no walk is requested but the timer still rearms.
- R10: On expiry with the wait bit 1, the timer stops (`poll_active`=0) and no walk is requested. A stopped timer never requests a walk.
- R11: A write with the wait bit at 1 does not stop a running timer before it expires. Each stop and wait bit takes the value of its most recent write. A bit written in the expiry cycle counts for that expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Write strobe of the DMA control register |
| ctl_rx_stop | input | 1 | Receive stop bit value being written |
| ctl_tx_stop | input | 1 | Transmit stop bit value being written |
| ctl_wait | input | 1 | Wait-or-poll bit value being written (1 = wait) |
| rx_busy | input | 1 | Receive path has a frame in progress |
| rx_frame_done | input | 1 | One-cycle end of a receive frame |
| tx_busy | input | 1 | Transmit path has a frame in progress |
| tx_frame_done | input | 1 | One-cycle end of a transmit frame |
| poll_tick | input | 1 | Prescaled polling tick, one cycle wide |
| rx_stop_done | output | 1 | Receive stop complete event pulse |
| tx_stop_done | output | 1 | Transmit stop complete event pulse |
| ring0_walk | output | 1 | Request to walk transmit ring 0 |
| poll_active | output | 1 | Poll timer is running |

## Verification
The assertions assume that each path raises its frame-done input only while its busy input is high. They also assume that a frame that has started always ends with a done pulse, so a pending stop is never stranded by busy simply dropping. The random stimulus keeps a frame flag per path. It starts frames at random and ends each one with a done pulse in a cycle where busy is still 1. Busy drops in the following cycle. Directed sequences place the frame end in the same cycle as a write and cover the cancel and expiry corners. They too respect that pairing.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    typedef enum logic [1:0] {
        STOP_IDLE = 2'd0,
        STOP_WAIT = 2'd1,
        STOP_FIRE = 2'd2
    } stop_state_e;

    typedef enum logic [1:0] {
        POLL_OFF  = 2'd0,
        POLL_RUN  = 2'd1,
        POLL_WALK = 2'd2
    } poll_state_e;

    localparam int NUM_PATHS = 2;
    localparam int PATH_RX   = 0;
    localparam int PATH_TX   = 1;

endpackage

// File: rtl/gsp_stop_fsm.sv
module gsp_stop_fsm
    import gsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic stop_bit_i,
    input  logic busy_i,
    input  logic done_i,
    output logic fire_o
);

    stop_state_e state_q;
    stop_state_e state_d;
    logic        in_flight;
    logic        req_set;
    logic        req_clr;

    assign in_flight = busy_i & ~done_i;
    assign req_set   = wr_i & stop_bit_i;
    assign req_clr   = wr_i & ~stop_bit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STOP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STOP_IDLE, STOP_FIRE: begin
                if (req_set) begin
                    state_d = in_flight ? STOP_WAIT : STOP_FIRE;
                end else begin
                    state_d = STOP_IDLE;
                end
            end
            STOP_WAIT: begin
                if (req_clr) begin
                    state_d = STOP_IDLE;
                end else if (done_i) begin
                    state_d = STOP_FIRE;
                end else begin
                    state_d = STOP_WAIT;
                end
            end
            default: state_d = STOP_IDLE;
        endcase
    end

    always_comb begin
        fire_o = (state_q == STOP_FIRE);
    end

endmodule

// File: rtl/gsp_poll_timer.sv
module gsp_poll_timer
    import gsp_pkg::*;
#(
    parameter int TICKS_PER_POLL = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wait_bit_i,
    input  logic tx_stop_bit_i,
    input  logic tick_i,
    output logic walk_o,
    output logic active_o
);

    localparam int CNT_W = (TICKS_PER_POLL > 1) ? $clog2(TICKS_PER_POLL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_POLL - 1);

    poll_state_e      state_q;
    poll_state_e      state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             wait_q;
    logic             gts_q;
    logic             wait_eff;
    logic             gts_eff;
    logic             restart;
    logic             running;
    logic             expire;

    assign wait_eff = wr_i ? wait_bit_i    : wait_q;
    assign gts_eff  = wr_i ? tx_stop_bit_i : gts_q;
    assign restart  = wr_i & ~wait_bit_i;
    assign running  = (state_q == POLL_RUN) || (state_q == POLL_WALK);
    assign expire   = running & tick_i & (cnt_q == CNT_LAST) & ~restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= POLL_OFF;
            cnt_q   <= '0;
            wait_q  <= 1'b0;
            gts_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (wr_i) begin
                wait_q <= wait_bit_i;
                gts_q  <= tx_stop_bit_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            POLL_OFF: begin
                if (restart) begin
                    state_d = POLL_RUN;
                    cnt_d   = '0;
                end
            end
            POLL_RUN, POLL_WALK: begin
                if (restart) begin
                    state_d = POLL_RUN;
                    cnt_d   = '0;
                end else if (expire) begin
                    cnt_d = '0;
                    if (wait_eff) begin
                        state_d = POLL_OFF;
                    end else if (gts_eff) begin
                        state_d = POLL_RUN;
                    end else begin
                        state_d = POLL_WALK;
                    end
                end else begin
                    state_d = POLL_RUN;
                    if (tick_i) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = POLL_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        walk_o   = (state_q == POLL_WALK);
        active_o = (state_q != POLL_OFF);
    end

endmodule

// File: rtl/graceful_stop_poll.sv
module graceful_stop_poll
    import gsp_pkg::*;
#(
    parameter int TICKS_PER_POLL = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_rx_stop,
    input  logic ctl_tx_stop,
    input  logic ctl_wait,
    input  logic rx_busy,
    input  logic rx_frame_done,
    input  logic tx_busy,
    input  logic tx_frame_done,
    input  logic poll_tick,
    output logic rx_stop_done,
    output logic tx_stop_done,
    output logic ring0_walk,
    output logic poll_active
);

    logic [NUM_PATHS-1:0] stop_bits;
    logic [NUM_PATHS-1:0] busy_bits;
    logic [NUM_PATHS-1:0] done_bits;
    logic [NUM_PATHS-1:0] fire_bits;

    assign stop_bits[PATH_RX] = ctl_rx_stop;
    assign stop_bits[PATH_TX] = ctl_tx_stop;
    assign busy_bits[PATH_RX] = rx_busy;
    assign busy_bits[PATH_TX] = tx_busy;
    assign done_bits[PATH_RX] = rx_frame_done;
    assign done_bits[PATH_TX] = tx_frame_done;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        gsp_stop_fsm u_stop (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (ctl_wr),
            .stop_bit_i (stop_bits[p]),
            .busy_i     (busy_bits[p]),
            .done_i     (done_bits[p]),
            .fire_o     (fire_bits[p])
        );
    end

    assign rx_stop_done = fire_bits[PATH_RX];
    assign tx_stop_done = fire_bits[PATH_TX];

    gsp_poll_timer #(
        .TICKS_PER_POLL (TICKS_PER_POLL)
    ) u_poll (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (ctl_wr),
        .wait_bit_i    (ctl_wait),
        .tx_stop_bit_i (ctl_tx_stop),
        .tick_i        (poll_tick),
        .walk_o        (ring0_walk),
        .active_o      (poll_active)
    );

endmodule

// File: rtl/gsp_checker.sv
module gsp_checker (
    input logic clk,
    input logic rst_n,
    input logic ctl_wr,
    input logic ctl_rx_stop,
    input logic ctl_tx_stop,
    input logic ctl_wait,
    input logic rx_busy,
    input logic rx_frame_done,
    input logic tx_busy,
    input logic tx_frame_done,
    input logic rx_stop_done,
    input logic tx_stop_done,
    input logic ring0_walk,
    input logic poll_active
);

    // R1: outputs quiet during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!rx_stop_done && !tx_stop_done && !ring0_walk && !poll_active)
                else $error("reset outputs not quiet");
        end
    end

    p_rx_at_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_rx_stop && !(rx_busy && !rx_frame_done) |=> rx_stop_done);

    p_tx_at_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_tx_stop && !(tx_busy && !tx_frame_done) |=> tx_stop_done);

    p_rx_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_rx_stop && rx_busy && !rx_frame_done |=> !rx_stop_done);

    p_rx_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_rx_stop |=> !rx_stop_done);

    p_tx_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_tx_stop |=> !tx_stop_done);

    p_rx_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stop_done && !ctl_wr |=> !rx_stop_done);

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_wait |=> poll_active && !ring0_walk);

    p_gts_no_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_tx_stop |=> !ring0_walk);

    p_off_no_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_active |=> !ring0_walk);

    p_walk_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ring0_walk |=> !ring0_walk);

endmodule

bind graceful_stop_poll gsp_checker u_gsp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_wr        (ctl_wr),
    .ctl_rx_stop   (ctl_rx_stop),
    .ctl_tx_stop   (ctl_tx_stop),
    .ctl_wait      (ctl_wait),
    .rx_busy       (rx_busy),
    .rx_frame_done (rx_frame_done),
    .tx_busy       (tx_busy),
    .tx_frame_done (tx_frame_done),
    .rx_stop_done  (rx_stop_done),
    .tx_stop_done  (tx_stop_done),
    .ring0_walk    (ring0_walk),
    .poll_active   (poll_active)
);

// File: tb/tb_graceful_stop_poll.sv
module tb_graceful_stop_poll;

    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_rx_stop = 0, ctl_tx_stop = 0, ctl_wait = 0;
    logic rx_busy = 0, rx_frame_done = 0, tx_busy = 0, tx_frame_done = 0;
    logic poll_tick = 0;
    logic rx_stop_done, tx_stop_done, ring0_walk, poll_active;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // reference model state
    bit m_rx_wait = 0, m_tx_wait = 0, m_wait = 0, m_gts = 0, m_run = 0;
    int m_cnt = 0;
    bit e_rx = 0, e_tx = 0, e_walk = 0, e_act = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    graceful_stop_poll #(.TICKS_PER_POLL(TICKS)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rx_stop(ctl_rx_stop),
        .ctl_tx_stop(ctl_tx_stop), .ctl_wait(ctl_wait), .rx_busy(rx_busy),
        .rx_frame_done(rx_frame_done), .tx_busy(tx_busy), .tx_frame_done(tx_frame_done),
        .poll_tick(poll_tick), .rx_stop_done(rx_stop_done), .tx_stop_done(tx_stop_done),
        .ring0_walk(ring0_walk), .poll_active(poll_active)
    );

    task automatic check(input logic act, input bit exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    // next completion of a stop sequencer, from the requirements
    function automatic bit stop_next(inout bit pend, input bit wr, input bit sbit,
                                     input bit busy, input bit done);
        bit fire = 0;
        if (pend) begin
            if (wr && !sbit) pend = 0;
            else if (done) begin pend = 0; fire = 1; end
        end else if (wr && sbit) begin
            if (busy && !done) pend = 1;
            else fire = 1;
        end
        return fire;
    endfunction

    function automatic void poll_next(input bit wr, input bit wt, input bit ts, input bit tk);
        bit wait_n = wr ? wt : m_wait;
        bit gts_n  = wr ? ts : m_gts;
        bit rs     = wr && !wt;
        e_walk = 0;
        if (rs) begin m_run = 1; m_cnt = 0; end
        else if (m_run && tk && m_cnt == TICKS-1) begin
            m_cnt = 0;
            if (wait_n) m_run = 0;
            else e_walk = !gts_n;
        end else if (m_run && tk) m_cnt++;
        if (wr) begin m_wait = wt; m_gts = ts; end
        e_act = m_run;
    endfunction

    task automatic cyc(input bit wr, input bit rs, input bit ts, input bit wt,
                       input bit rb, input bit rd, input bit tb, input bit td, input bit tk);
        @(negedge clk);
        check(rx_stop_done, e_rx,   "R2 R3 R5 R6 rx_stop_done");
        check(tx_stop_done, e_tx,   "R4 R5 tx_stop_done");
        check(ring0_walk,   e_walk, "R8 R9 R10 ring0_walk");
        check(poll_active,  e_act,  "R7 R10 R11 poll_active");
        ctl_wr = wr; ctl_rx_stop = rs; ctl_tx_stop = ts; ctl_wait = wt;
        rx_busy = rb; rx_frame_done = rd; tx_busy = tb; tx_frame_done = td;
        poll_tick = tk;
        e_rx = stop_next(m_rx_wait, wr, rs, rb, rd);
        e_tx = stop_next(m_tx_wait, wr, ts, tb, td);
        poll_next(wr, wt, ts, tk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit rxf, txf;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rx_stop_done, 0, "R1"); check(tx_stop_done, 0, "R1");
        check(ring0_walk, 0, "R1");   check(poll_active, 0, "R1");
        rst_n = 1'b1;
        idle(2);

        // R2: immediate receive stop, then R6 single pulse
        cyc(1, 1, 0, 1, 0, 0, 0, 0, 0);
        idle(3);
        // R3: deferred receive stop
        cyc(0, 0, 0, 1, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 1, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 1, 0, 0, 0);
        idle(2);
        // R2: frame ending in the write cycle counts as idle
        cyc(1, 1, 0, 1, 1, 1, 0, 0, 0);
        idle(2);
        // R4 deferred transmit stop, then R5 cancel with same-cycle frame end
        cyc(1, 0, 1, 1, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 1, 1, 0);
        cyc(1, 0, 1, 1, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 1, 1, 0);
        idle(2);
        // R6 back-to-back writes each complete
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 0);
        idle(2);
        // R7 R8: start polling, count ticks to expiry and walk
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3*TICKS; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R9: transmit stop held, no walks
        cyc(1, 0, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 2*TICKS; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R11 then R10: wait bit set, timer runs on until expiry then halts
        cyc(1, 0, 0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 2*TICKS; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R11: bit written in the expiry cycle applies
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < TICKS-1; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
        cyc(1, 0, 0, 1, 0, 0, 0, 0, 1);
        idle(3);

        // constrained random
        rxf = 0; txf = 0;
        for (int n = 0; n < 4000; n++) begin
            bit wr, rs, ts, wt, rd, td, tk, rb, tb;
            wr = ($urandom % 8) == 0;
            rs = $urandom % 2; ts = ($urandom % 3) == 0; wt = ($urandom % 4) == 0;
            tk = $urandom % 2;
            if (!rxf) rxf = ($urandom % 5) == 0;
            if (!txf) txf = ($urandom % 5) == 0;
            rb = rxf; tb = txf;
            rd = rxf && (($urandom % 6) == 0);
            td = txf && (($urandom % 6) == 0);
            if (rd) rxf = 0;
            if (td) txf = 0;
            cyc(wr, wr & rs, wr & ts, wr & wt, rb, rd, tb, td, tk);
        end
        idle(2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule